// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block decides when the device may enter one of two low-power states (a light one, "suspend", and a deep one, "sleep") and when it returns to the active state. Peripheral event lines set sticky flags, and software reads these flags to find out what woke the part. A configuration write chooses which events may end a low-power state. The same write also asks for entry. Entry is refused while a flag belonging to one of the newly chosen sources is already set, so the device cannot go to sleep over an event that has already happened.

Every wake clears the source selection, so software must select the sources again on each entry. The active-low reset pin wakes the device from either low-power state whatever the selection. After the pin's falling edge the block stays awake for a fixed number of cycles, and then issues a one-cycle reset request. That count is a parameter, and it is chosen so that the awake time meets the minimum time the reset needs.

Top module: `wk_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 (active), and `flags_o`, `en_o`, `wake_o` and `pin_rst_o` are all 0.
- R2: A high bit on `evt_i` sets the matching flag at the next clock edge, whether or not that source is enabled. The flag then stays set until it is cleared.
- R3: When `clr_we_i` is high, each flag whose bit in `clr_mask_i` is 1 is cleared. An event in the same cycle keeps its flag set. When `clr_we_i` is low, `clr_mask_i` has no effect.
- R4: A config write (`cfg_we_i`) while active loads `cfg_en_i` into `en_o`. If only `cfg_susp_i` is set, `mode_o` becomes 1 (suspend). If `cfg_sleep_i` is set, `mode_o` becomes 2 (sleep), and this includes the case where both bits are set. A config write while not active has no effect.
- R5: An entry command is refused, and `mode_o` stays 0, when any current flag is set under a bit of the `cfg_en_i` value written with it. The enables are still loaded.
- R6: In suspend or sleep, once a flag whose source is enabled is set, the next clock edge sets `mode_o` to 0 and clears `en_o`. At that edge `wake_o` goes high, and it stays high for exactly one cycle.
- R7: In a low-power state, an event on a disabled source sets its flag but leaves `mode_o` and `wake_o` unchanged.
- R8: A falling edge on `pin_ni` in suspend or sleep wakes the block at the next edge, as in R6, even when `en_o` is 0.
- R9: `pin_rst_o` pulses high for one cycle exactly `HOLD_CYCLES` clock edges after the edge at which the falling edge of `pin_ni` was taken.
- R10: Flags keep latching events after a wake, and they stay readable until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_en_i | input | NUM_SRC | Source enables written with the strobe |
| cfg_susp_i | input | 1 | Request suspend |
| cfg_sleep_i | input | 1 | Request sleep (takes precedence over suspend) |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | NUM_SRC | Write-1-to-clear flag mask |
| evt_i | input | NUM_SRC | Peripheral event lines |
| pin_ni | input | 1 | Synchronised reset pin, active low |
| mode_o | output | 2 | 0 active, 1 suspend, 2 sleep |
| wake_o | output | 1 | One-cycle wake pulse |
| en_o | output | NUM_SRC | Current source enables |
| flags_o | output | NUM_SRC | Sticky wake flags |
| pin_rst_o | output | 1 | One-cycle reset request after the hold interval |

## Verification
The flag logic is driven with a sequence of event and clear patterns: single events, events that overlap other set flags, a clear together with an event on the same bit, and a clear mask given without its strobe. Together these separate a correct sticky write-1-to-clear register from one that loses events or clears too much. The entry gate is tried with a clean flag set and with a stale flag under a newly written enable, which separates accepted commands from refused ones. The wake paths are tried with a disabled event, an enabled event and a pin edge with no sources enabled. These show whether wake depends on the enables, and whether the pin bypasses them. The reset request is sampled one cycle before, at, and one cycle after its expected edge, so that an off-by-one in the hold count is caught.

// File: rtl/wk_pkg.sv
package wk_pkg;
    typedef enum logic [1:0] {
        MODE_ACTIVE  = 2'd0,
        MODE_SUSPEND = 2'd1,
        MODE_SLEEP   = 2'd2
    } mode_e;
endpackage

// File: rtl/wk_flags.sv
module wk_flags #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clr_we_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [NUM_SRC-1:0] flags_o
);
    logic [NUM_SRC-1:0] flags_d, flags_q;
    logic [NUM_SRC-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_we_i ? clr_mask_i : '0;
        // event wins over a clear of the same bit
        flags_d = (flags_q & ~clr_eff) | evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flags_q <= '0;
        else         flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    assert_flag_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_we_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    assert_event_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != '0) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/wk_pin_hold.sv
module wk_pin_hold #(
    parameter int HOLD_CYCLES = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_ni,
    output logic fall_o,
    output logic rst_req_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
        logic          req;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_ni;
        st_d.req  = 1'b0;
        fall_o    = st_q.prev & ~pin_ni;
        if (fall_o) begin
            st_d.cnt = CW'(HOLD_CYCLES);
        end else if (st_q.cnt == CW'(1)) begin
            st_d.cnt = '0;
            st_d.req = 1'b1;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{prev: 1'b1, cnt: '0, req: 1'b0};
        else         st_q <= st_d;
    end

    assign rst_req_o = st_q.req;

    assert_rst_req_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.req |=> !st_q.req);

    assert_cnt_loaded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> (st_q.cnt == CW'(HOLD_CYCLES)));
endmodule

// File: rtl/wk_ctrl.sv
module wk_ctrl #(
    parameter int NUM_SRC     = 4,
    parameter int HOLD_CYCLES = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_we_i,
    input  logic [NUM_SRC-1:0] cfg_en_i,
    input  logic               cfg_susp_i,
    input  logic               cfg_sleep_i,
    input  logic               clr_we_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               pin_ni,
    output logic [1:0]         mode_o,
    output logic               wake_o,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] flags_o,
    output logic               pin_rst_o
);
    import wk_pkg::*;

    typedef struct packed {
        mode_e              mode;
        logic [NUM_SRC-1:0] en;
        logic               wake;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [NUM_SRC-1:0] flags_q;
    logic               pin_fall;
    logic               src_hit;
    logic               entry_req;
    logic               entry_ok;

    wk_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .evt_i      (evt_i),
        .flags_o    (flags_q)
    );

    wk_pin_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_pin (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pin_ni    (pin_ni),
        .fall_o    (pin_fall),
        .rst_req_o (pin_rst_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        src_hit   = (flags_q & st_q.en) != '0;
        entry_req = cfg_susp_i | cfg_sleep_i;
        entry_ok  = ((flags_q & cfg_en_i) == '0) && !pin_fall;
        if (st_q.mode != MODE_ACTIVE) begin
            if (src_hit || pin_fall) begin
                st_d.mode = MODE_ACTIVE;
                st_d.en   = '0;
                st_d.wake = 1'b1;
            end
        end else if (cfg_we_i) begin
            st_d.en = cfg_en_i;
            if (entry_req && entry_ok) begin
                st_d.mode = cfg_sleep_i ? MODE_SLEEP : MODE_SUSPEND;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{mode: MODE_ACTIVE, en: '0, wake: 1'b0};
        else         st_q <= st_d;
    end

    assign mode_o  = st_q.mode;
    assign wake_o  = st_q.wake;
    assign en_o    = st_q.en;
    assign flags_o = flags_q;

    assert_wake_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.wake |=> !st_q.wake);

    assert_wake_lands_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.wake |-> (st_q.mode == MODE_ACTIVE && st_q.en == '0));

    assert_entry_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == MODE_ACTIVE && st_d.mode != MODE_ACTIVE) |=>
            (($past(flags_q) & st_q.en) == '0));

    assert_mode_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.mode != 2'd3);
endmodule

// File: tb/tb_wk_ctrl.sv
module tb_wk_ctrl;
    localparam int N    = 4;
    localparam int HOLD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_susp = 1'b0, cfg_sleep = 1'b0, clr_we = 1'b0;
    logic [N-1:0] cfg_en = '0, clr_mask = '0, evt = '0;
    logic pin_n = 1'b1;
    logic [1:0] mode;
    logic wake, pin_rst;
    logic [N-1:0] en, flags;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wk_ctrl #(.NUM_SRC(N), .HOLD_CYCLES(HOLD)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
        .cfg_susp_i(cfg_susp), .cfg_sleep_i(cfg_sleep), .clr_we_i(clr_we),
        .clr_mask_i(clr_mask), .evt_i(evt), .pin_ni(pin_n), .mode_o(mode),
        .wake_o(wake), .en_o(en), .flags_o(flags), .pin_rst_o(pin_rst)
    );

    // {evt, clr_we, clr_mask, expected flags}
    localparam logic [12:0] VEC [9] = '{
        {4'b0001, 1'b0, 4'b0000, 4'b0001},
        {4'b0100, 1'b0, 4'b0000, 4'b0101},
        {4'b0000, 1'b1, 4'b0001, 4'b0100},
        {4'b0010, 1'b1, 4'b0010, 4'b0110},
        {4'b0000, 1'b0, 4'b1111, 4'b0110},
        {4'b0000, 1'b1, 4'b1111, 4'b0000},
        {4'b1000, 1'b0, 4'b0000, 4'b1000},
        {4'b1000, 1'b1, 4'b1000, 4'b1000},
        {4'b0000, 1'b1, 4'b1111, 4'b0000}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [N-1:0] e, input logic su, input logic sl);
        cfg_we = 1'b1; cfg_en = e; cfg_susp = su; cfg_sleep = sl;
        cyc();
        cfg_we = 1'b0; cfg_susp = 1'b0; cfg_sleep = 1'b0; cfg_en = '0;
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_mask = '1;
        cyc();
        clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic pulse_evt(input logic [N-1:0] e);
        evt = e;
        cyc();
        evt = '0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mode", mode, 0);
        chk("R1 flags", flags, 0);
        chk("R1 wake", wake, 0);
        chk("R1 pin_rst", pin_rst, 0);
        rst_n = 1'b1;
        cyc();
        chk("R1 en", en, 0);

        // R2/R3 flag table
        foreach (VEC[i]) begin
            evt = VEC[i][12:9]; clr_we = VEC[i][8]; clr_mask = VEC[i][7:4];
            cyc();
            chk($sformatf("R2/R3 vector %0d", i), flags, VEC[i][3:0]);
        end
        evt = '0; clr_we = 1'b0; clr_mask = '0;

        // R4 suspend entry
        cfg_write(4'b0001, 1'b1, 1'b0);
        chk("R4 suspend mode", mode, 1);
        chk("R4 enables", en, 1);
        // R4 write while not active ignored
        cfg_write(4'b1111, 1'b0, 1'b1);
        chk("R4 ignored write mode", mode, 1);
        chk("R4 ignored write en", en, 1);
        // R7 disabled event
        pulse_evt(4'b0010);
        cyc();
        chk("R7 mode", mode, 1);
        chk("R7 wake", wake, 0);
        chk("R7 flag", flags, 2);
        // R6 enabled event
        evt = 4'b0001;
        cyc();
        evt = '0;
        chk("R6 not yet", mode, 1);
        cyc();
        chk("R6 mode", mode, 0);
        chk("R6 wake", wake, 1);
        chk("R6 en cleared", en, 0);
        cyc();
        chk("R6 wake one cycle", wake, 0);
        chk("R6 flags readable", flags, 3);
        // R10 flags still update after wake
        pulse_evt(4'b1000);
        chk("R10 flags", flags, 4'b1011);
        clear_all();

        // R4 both bits -> sleep
        cfg_write(4'b0010, 1'b1, 1'b1);
        chk("R4 both is sleep", mode, 2);
        pulse_evt(4'b0010);
        cyc();
        chk("R6 sleep wake", wake, 1);
        chk("R6 sleep mode", mode, 0);
        clear_all();

        // R5 refusal
        pulse_evt(4'b0100);
        cfg_write(4'b0100, 1'b0, 1'b1);
        chk("R5 refused mode", mode, 0);
        chk("R5 en loaded", en, 4'b0100);
        cfg_write(4'b0011, 1'b1, 1'b0);
        chk("R5 unrelated flag allows", mode, 1);
        pulse_evt(4'b0001);
        cyc();
        chk("R6 wake again", mode, 0);
        clear_all();

        // R8/R9 pin wake from sleep with no enables
        cfg_write(4'b0000, 1'b0, 1'b1);
        chk("R8 sleep", mode, 2);
        pin_n = 1'b0;
        cyc();
        chk("R8 mode", mode, 0);
        chk("R8 wake", wake, 1);
        repeat (HOLD - 1) @(posedge clk);
        @(negedge clk);
        chk("R9 before", pin_rst, 0);
        cyc();
        chk("R9 at", pin_rst, 1);
        cyc();
        chk("R9 after", pin_rst, 0);
        pin_n = 1'b1;
        cyc();

        // R8 from suspend
        cfg_write(4'b0000, 1'b1, 1'b0);
        pin_n = 1'b0;
        cyc();
        chk("R8 suspend pin wake", mode, 0);
        pin_n = 1'b1;
        repeat (HOLD + 2) cyc();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule